// File: doc/BRIEF.md
# PWM Counter Event Trigger Generator

This block sits beside the counter of one PWM generator and turns chosen counter events into two outputs: a level interrupt request and a one-clock pulse that starts an ADC conversion. On each counter step it compares the new count with the load value, with zero, and with two compare values. The compare matches are split by the current count direction, which gives six distinct events.

A single 32-bit enable word, written over a small register port, chooses which events feed each path. The two paths have separate enables. Interrupt events latch into sticky raw status bits that software clears by writing ones. Trigger events are combined into one pulse that does not record which event caused it.

Top module: `pwm_event_trig`

## Requirements
- R1: Six events are detected on a clock where `cnt_en` is high. Their bit indices are 0 = count equals zero, 1 = count equals load, 2 = count equals compare A with `cnt_up`=1, 3 = count equals compare A with `cnt_up`=0, 4 = count equals compare B with `cnt_up`=1, 5 = count equals compare B with `cnt_up`=0. A compare match in the other direction does not raise the event.
- R2: Address 0 holds the enable word. Bits 5:0 are the interrupt enables and bits 13:8 are the trigger enables, both in the event order of R1. Reading address 0 returns the stored bits.
- R3: Enable-word bits 7:6 and 31:14 read as 0, and writes to them are ignored. Addresses 2 and 3 read as 0, and writes to them have no effect.
- R4: After reset the enable word and the status are 0, and `irq` and `adc_trig` are low.
- R5: `adc_trig` is high for exactly one clock, the clock after a step edge on which any enabled trigger event occurred. Coinciding events still give a single pulse.
- R6: Address 1 reads the raw status in the event order of R1. An enabled interrupt event sets its bit, and the bit stays set until a write of 1 to that bit position at address 1.
- R7: `irq` is high whenever any status bit is set.
- R8: A register write takes effect at the clock edge where it is accepted. An event at that same edge is judged against the enable word held before the write.
- R9: When a status bit is set by an event and cleared by a write at the same edge, the bit ends up set. A clear of other bits at that edge still takes effect.
- R10: A matching count presented while `cnt_en` is low raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter step strobe; the count below is new this clock |
| cnt_val | input | CNT_W | Current counter value |
| cnt_up | input | 1 | Count direction: 1 up, 0 down |
| load_val | input | CNT_W | Counter load (period) value |
| cmpa_val | input | CNT_W | Compare A value |
| cmpb_val | input | CNT_W | Compare B value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| adc_trig | output | 1 | One-clock ADC trigger pulse |

## Verification
Two things can land on the same clock edge: a counter event, and a register write that changes the enables or clears status. The bench provokes this directly by driving a write and a counter step together at one edge. In one case the write turns enables on while a zero match arrives; the expected result is no status and no trigger, followed by a normal fire on the next step. In the other case a write-one clear hits a status bit that the same edge sets again; that bit is expected to stay set while the other cleared bit drops.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

    localparam int NUM_EVT  = 6;
    localparam int NUM_CMP  = 2;
    localparam int TRIG_LSB = 8;

    localparam int REG_ENABLE = 0;
    localparam int REG_STATUS = 1;

    typedef enum logic [2:0] {
        EV_ZERO = 3'd0,
        EV_LOAD = 3'd1,
        EV_AUP  = 3'd2,
        EV_ADN  = 3'd3,
        EV_BUP  = 3'd4,
        EV_BDN  = 3'd5
    } evt_idx_e;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef struct packed {
        evt_vec_t int_en;
        evt_vec_t trig_en;
        evt_vec_t status;
    } regs_state_t;

    typedef struct packed {
        logic trig;
    } pulse_state_t;

endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                           step,
    input  logic [CNT_W-1:0]               cnt,
    input  logic                           up,
    input  logic [CNT_W-1:0]               load,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp,
    output evt_vec_t                       events
);

    logic [NUM_CMP-1:0] hit_up;
    logic [NUM_CMP-1:0] hit_dn;

    // One comparator per compare register, each split by direction
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        logic eq;
        assign eq        = (cnt == cmp[g]);
        assign hit_up[g] = step && eq && up;
        assign hit_dn[g] = step && eq && !up;
    end

    always_comb begin
        events          = '0;
        events[EV_ZERO] = step && (cnt == '0);
        events[EV_LOAD] = step && (cnt == load);
        for (int k = 0; k < NUM_CMP; k++) begin
            events[int'(EV_AUP) + 2*k] = hit_up[k];
            events[int'(EV_ADN) + 2*k] = hit_dn[k];
        end
    end

endmodule

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
    import pwm_evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  evt_vec_t          events,
    output evt_vec_t          int_en,
    output evt_vec_t          trig_en,
    output evt_vec_t          status
);

    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(REG_ENABLE);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(REG_STATUS);

    regs_state_t st_d, st_q;
    evt_vec_t    clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (wr && addr == A_EN) begin
            st_d.int_en  = wdata[NUM_EVT-1:0];
            st_d.trig_en = wdata[TRIG_LSB +: NUM_EVT];
        end
        if (wr && addr == A_ST) begin
            clr_mask = wdata[NUM_EVT-1:0];
        end
        // Events use the enables held before this edge; a new set beats a clear
        st_d.status = (st_q.status & ~clr_mask) | (events & st_q.int_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_EN) begin
            rdata[NUM_EVT-1:0]          = st_q.int_en;
            rdata[TRIG_LSB +: NUM_EVT]  = st_q.trig_en;
        end else if (addr == A_ST) begin
            rdata[NUM_EVT-1:0]          = st_q.status;
        end
    end

    assign int_en  = st_q.int_en;
    assign trig_en = st_q.trig_en;
    assign status  = st_q.status;

endmodule

// File: rtl/pwm_evt_pulse.sv
module pwm_evt_pulse
    import pwm_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t events,
    input  evt_vec_t trig_en,
    input  evt_vec_t status,
    output logic     adc_trig,
    output logic     irq
);

    pulse_state_t ps_d, ps_q;

    always_comb begin
        ps_d      = ps_q;
        ps_d.trig = |(events & trig_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign adc_trig = ps_q.trig;
    assign irq      = |status;

endmodule

// File: rtl/pwm_event_trig.sv
module pwm_event_trig
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_up,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  cmpa_val,
    input  logic [CNT_W-1:0]  cmpb_val,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              adc_trig
);

    evt_vec_t                      events;
    evt_vec_t                      int_en;
    evt_vec_t                      trig_en;
    evt_vec_t                      status;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_bus;

    assign cmp_bus = {cmpb_val, cmpa_val};

    pwm_evt_detect #(.CNT_W(CNT_W)) u_detect (
        .step   (cnt_en),
        .cnt    (cnt_val),
        .up     (cnt_up),
        .load   (load_val),
        .cmp    (cmp_bus),
        .events (events)
    );

    pwm_evt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .events  (events),
        .int_en  (int_en),
        .trig_en (trig_en),
        .status  (status)
    );

    pwm_evt_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .trig_en  (trig_en),
        .status   (status),
        .adc_trig (adc_trig),
        .irq      (irq)
    );

endmodule

// File: rtl/pwm_event_trig_chk.sv
module pwm_event_trig_chk
    import pwm_evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              adc_trig,
    input evt_vec_t          int_en,
    input evt_vec_t          status
);

    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(REG_ENABLE);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(REG_STATUS);

    assert_trig_after_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> $past(cnt_en));

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_ST) |=> ((status & $past(status)) == $past(status)));

    assert_irq_rise_from_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cnt_en));

    assert_no_set_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |=> ((status & ~$past(status)) == '0));

    assert_enable_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EN) |=> (int_en == $past(reg_wdata[NUM_EVT-1:0])));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_EN) |-> (reg_rdata[DATA_W-1:TRIG_LSB+NUM_EVT] == '0 &&
                                reg_rdata[TRIG_LSB-1:NUM_EVT] == '0));

endmodule

bind pwm_event_trig pwm_event_trig_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .adc_trig  (adc_trig),
    .int_en    (int_en),
    .status    (status)
);

// File: tb/tb_pwm_event_trig.sv
module tb_pwm_event_trig;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_en = 1'b0;
    logic [CNT_W-1:0]  cnt_val = '0;
    logic              cnt_up = 1'b1;
    logic [CNT_W-1:0]  load_val = 16'd100;
    logic [CNT_W-1:0]  cmpa_val = 16'd40;
    logic [CNT_W-1:0]  cmpb_val = 16'd70;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;
    logic              adc_trig;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_event_trig #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .load_val(load_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .adc_trig(adc_trig)
    );

    typedef struct packed {
        logic [13:0] en;
        logic [15:0] cnt;
        logic        up;
        logic [15:0] load;
        logic [15:0] ca;
        logic [15:0] cb;
        logic        trig;
        logic [5:0]  st;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{14'h3F3F, 16'd0,   1'b1, 16'd100, 16'd40, 16'd70, 1'b1, 6'h01},
        '{14'h3F3F, 16'd100, 1'b1, 16'd100, 16'd40, 16'd70, 1'b1, 6'h02},
        '{14'h3F3F, 16'd40,  1'b1, 16'd100, 16'd40, 16'd70, 1'b1, 6'h04},
        '{14'h3F3F, 16'd40,  1'b0, 16'd100, 16'd40, 16'd70, 1'b1, 6'h08},
        '{14'h3F3F, 16'd70,  1'b1, 16'd100, 16'd40, 16'd70, 1'b1, 6'h10},
        '{14'h3F3F, 16'd70,  1'b0, 16'd100, 16'd40, 16'd70, 1'b1, 6'h20},
        '{14'h0004, 16'd40,  1'b0, 16'd100, 16'd40, 16'd70, 1'b0, 6'h00},
        '{14'h0800, 16'd40,  1'b0, 16'd100, 16'd40, 16'd70, 1'b1, 6'h00},
        '{14'h0008, 16'd40,  1'b0, 16'd100, 16'd40, 16'd70, 1'b0, 6'h08},
        '{14'h3F3F, 16'd55,  1'b1, 16'd100, 16'd40, 16'd70, 1'b0, 6'h00},
        '{14'h3F3F, 16'd40,  1'b1, 16'd100, 16'd40, 16'd40, 1'b1, 6'h14},
        '{14'h2000, 16'd70,  1'b1, 16'd100, 16'd40, 16'd70, 1'b0, 6'h00},
        '{14'h3F3F, 16'd0,   1'b0, 16'd0,   16'd40, 16'd70, 1'b1, 6'h03},
        '{14'h0100, 16'd100, 1'b1, 16'd100, 16'd40, 16'd70, 1'b0, 6'h00},
        '{14'h0200, 16'd100, 1'b0, 16'd100, 16'd40, 16'd70, 1'b1, 6'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // One counter step; returns at the negedge where the registered pulse is visible
    task automatic step(input logic [15:0] c, input logic u);
        @(negedge clk);
        cnt_en = 1'b1; cnt_val = c; cnt_up = u;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    // Reference event vector built from the event definitions of R1
    function automatic logic [5:0] ev_ref(input logic [15:0] c, input logic u,
                                          input logic [15:0] ld, input logic [15:0] a,
                                          input logic [15:0] b);
        logic [5:0] e;
        e[0] = (c == 16'd0);
        e[1] = (c == ld);
        e[2] = (c == a) &&  u;
        e[3] = (c == a) && !u;
        e[4] = (c == b) &&  u;
        e[5] = (c == b) && !u;
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R4 reset state
        reg_read(2'd0, rd); check("R4 enable reset", rd, 32'h0);
        reg_read(2'd1, rd); check("R4 status reset", rd, 32'h0);
        check("R4 irq reset", {31'b0, irq}, 32'h0);
        check("R4 trig reset", {31'b0, adc_trig}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        // R4: events with everything disabled do nothing
        step(16'd0, 1'b1);
        check("R4 trig disabled", {31'b0, adc_trig}, 32'h0);
        reg_read(2'd1, rd); check("R4 status disabled", rd, 32'h0);

        // R2 / R3 enable word fields and reserved bits
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, rd); check("R2 R3 enable readback", rd, 32'h0000_3F3F);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd2, rd); check("R3 unused address", rd, 32'h0);
        reg_read(2'd0, rd); check("R3 enable unchanged", rd, 32'h0000_3F3F);

        // Vector table: R1 R2 R5 R6
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd1, 32'h3F);
            reg_write(2'd0, {18'b0, VECS[i].en});
            load_val = VECS[i].load; cmpa_val = VECS[i].ca; cmpb_val = VECS[i].cb;
            step(VECS[i].cnt, VECS[i].up);
            check($sformatf("R1 R5 vec %0d trig", i), {31'b0, adc_trig}, {31'b0, VECS[i].trig});
            reg_read(2'd1, rd);
            check($sformatf("R1 R6 vec %0d status", i), rd, {26'b0, VECS[i].st});
        end
        load_val = 16'd100; cmpa_val = 16'd40; cmpb_val = 16'd70;

        // R10: matching count held with strobe low
        reg_write(2'd1, 32'h3F);
        reg_write(2'd0, 32'h3F3F);
        @(negedge clk); cnt_val = 16'd0; cnt_up = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 no trig while idle", {31'b0, adc_trig}, 32'h0);
        reg_read(2'd1, rd); check("R10 no status while idle", rd, 32'h0);

        // R5 pulse width, R7 irq follows status
        step(16'd0, 1'b1);
        check("R5 pulse high", {31'b0, adc_trig}, 32'h1);
        check("R7 irq set", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R5 pulse one clock", {31'b0, adc_trig}, 32'h0);
        reg_write(2'd1, 32'h01);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);
        reg_read(2'd1, rd); check("R6 write-one clear", rd, 32'h0);

        // R8: write and event at the same edge
        reg_write(2'd0, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0101;
        cnt_en = 1'b1; cnt_val = 16'd0; cnt_up = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; cnt_en = 1'b0;
        check("R8 old enables at write edge trig", {31'b0, adc_trig}, 32'h0);
        reg_read(2'd1, rd); check("R8 old enables at write edge status", rd, 32'h0);
        step(16'd0, 1'b1);
        check("R8 new enables next step trig", {31'b0, adc_trig}, 32'h1);
        reg_read(2'd1, rd); check("R8 new enables next step status", rd, 32'h01);

        // R9: set beats clear at the same edge
        reg_write(2'd1, 32'h3F);
        reg_write(2'd0, 32'h0005);
        step(16'd40, 1'b1);
        step(16'd0, 1'b1);
        reg_read(2'd1, rd); check("R9 setup status", rd, 32'h05);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h05;
        cnt_en = 1'b1; cnt_val = 16'd0; cnt_up = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; cnt_en = 1'b0;
        reg_read(2'd1, rd); check("R9 set wins, other bit clears", rd, 32'h01);

        // R1 R5 R6: up/down counter model, period 9, compares at 3 and 6
        reg_write(2'd1, 32'h3F);
        reg_write(2'd0, 32'h3F3F);
        load_val = 16'd9; cmpa_val = 16'd3; cmpb_val = 16'd6;
        begin
            logic [15:0] c;
            logic        u;
            int          pulses;
            c = 16'd0; u = 1'b1; pulses = 0;
            for (int s = 0; s < 36; s++) begin
                logic [5:0] e;
                e = ev_ref(c, u, load_val, cmpa_val, cmpb_val);
                step(c, u);
                check($sformatf("R1 R5 counter step %0d", s), {31'b0, adc_trig}, {31'b0, |e});
                if (adc_trig) pulses++;
                if (u) begin
                    if (c == load_val) begin u = 1'b0; c = c - 16'd1; end
                    else c = c + 16'd1;
                end else begin
                    if (c == 16'd0) begin u = 1'b1; c = 16'd1; end
                    else c = c - 16'd1;
                end
            end
            check("R1 counter pulse count", pulses, 32'd12);
        end
        reg_read(2'd1, rd); check("R6 counter status all", rd, 32'h3F);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule